// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side command decoder of a serial NOR flash. It runs in SPI mode 0 and works entirely in the system clock domain. Chip select, serial clock and the single data input pass through a short synchronizer. The block then finds serial clock edges and shifts in the command most significant bit first. The first byte is the opcode. Depending on the opcode it is followed by address bytes, a dummy byte, data bytes, or nothing.

Each opcode falls into one of two classes. A read-type command turns the data output on once its header is complete, and the master may end that output phase after any bit. A write-type command only takes effect when chip select rises after a whole number of bytes. Program, erase and status-write commands also need the write-enable latch to be set. Such a command then starts a simulated busy interval. During that interval, commands that touch the array, and status writes, are dropped.

The memory array sits outside this block. Array reads are served through a combinational read port. Page-program data bytes are offered as they arrive, and the consumer keeps them only if the command pulse follows.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Bits are taken MSB first on rising serial clock edges. Output bits change on falling edges. The first output bit is driven on the falling edge after the last header bit. `spi_miso_oe` is high only in a data-out phase with chip select low. Read status (0x05) returns the status byte: bit 0 busy, bit 1 write-enable latch, bits 7:2 the stored upper field. The byte repeats for as long as clocking continues.
- R2: Read ID (0x9F) returns the three bytes of `DEV_ID`, most significant byte first, and then repeats them.
- R3: Read (0x03) takes a 3-byte address and returns array bytes from consecutive addresses. Fast read (0x0B) does the same after one extra dummy byte.
- R4: Chip select may rise in the middle of an output byte with no side effect. The next command decodes normally.
- R5: A write-type command acts only if the number of rising clock edges while selected is a non-zero multiple of 8. Otherwise nothing changes.
- R6: Write enable (0x06) sets the latch and write disable (0x04) clears it. Both work while busy.
- R7: Page program (0x02), subsector erase (0x20), sector erase (0xD8), bulk erase (0xC7) and write status (0x01) need the latch. Page program needs address plus at least one data byte, the erases need their address, and write status needs one data byte. When accepted, the command pulses `wr_cmd_valid` with its opcode and address and clears the latch. Without the latch it is dropped.
- R8: An accepted command from R7 sets status bit 0 for exactly `BUSY_CLKS` system clocks.
- R9: While busy, read, fast read, the program and erase commands, and write status give no output and no effect. Read status still works.
- R10: Write status stores bits 7:2 of its data byte as status bits 7:2.
- R11: Deep power-down (0xB9) makes every opcode except release (0xAB) be ignored. Release returns `DEV_ID[7:0]` and leaves power-down when chip select rises.
- R12: Each page-program data byte appears on `prog_byte` with a one-cycle `prog_byte_valid` as it completes.
- R13: After reset the output is disabled, no command pulse is pending, and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for serial data out |
| arr_addr | output | 24 | Array read address |
| arr_rd_en | output | 1 | Array read phase active |
| arr_rd_data | input | 8 | Array byte at `arr_addr`, combinational |
| prog_byte_valid | output | 1 | Page-program data byte strobe |
| prog_byte | output | 8 | Page-program data byte |
| wr_cmd_valid | output | 1 | Accepted program/erase/status-write pulse |
| wr_cmd_op | output | 8 | Opcode of the accepted command |
| wr_cmd_addr | output | 24 | Address of the accepted command |

## Verification
A corrupt bit counter or byte index shows up within a single transaction. It either misaligns the status byte read back, or it accepts or rejects a write-enable that was cut at some other bit count. The sweep of every cut point from 1 to 24 bits exposes this on the next status read. A stuck latch, busy counter or power-down flag shows up within one further command: a read that should not drive does, a dropped program still pulses, or the busy bit is wrong at the next status read.

// File: rtl/flash_fe_pkg.sv
// Package: opcode values, command classes and per-opcode length rules.
// Assumes addresses are a whole number of bytes.
package flash_fe_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SSE   = 8'h20;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_BE    = 8'hC7;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_DP    = 8'hB9;
    localparam logic [7:0] OP_RES   = 8'hAB;

    typedef enum logic [1:0] {CL_NONE, CL_READ, CL_WRITE} cmd_class_e;

    // Sort an opcode into its class.
    function automatic cmd_class_e op_class(input logic [7:0] op);
        case (op)
            OP_READ, OP_FAST, OP_RDSR, OP_RDID, OP_RES: return CL_READ;
            OP_WREN, OP_WRDI, OP_PP, OP_SSE, OP_SE,
            OP_BE, OP_WRSR, OP_DP:                       return CL_WRITE;
            default:                                     return CL_NONE;
        endcase
    endfunction

    // Commands that touch the memory array.
    function automatic logic op_is_array(input logic [7:0] op);
        return (op == OP_READ) || (op == OP_FAST) || (op == OP_PP) ||
               (op == OP_SSE)  || (op == OP_SE)   || (op == OP_BE);
    endfunction

    // Commands that need the write-enable latch and start a busy cycle.
    function automatic logic op_needs_wel(input logic [7:0] op);
        return (op == OP_PP) || (op == OP_SSE) || (op == OP_SE) ||
               (op == OP_BE) || (op == OP_WRSR);
    endfunction

    // Bytes received before a read-type command starts output.
    function automatic int hdr_len(input logic [7:0] op, input int abytes);
        case (op)
            OP_READ: return 1 + abytes;
            OP_FAST: return 2 + abytes;
            default: return 1;
        endcase
    endfunction

    // Minimum bytes for a write-type command to be complete.
    function automatic int min_len(input logic [7:0] op, input int abytes);
        case (op)
            OP_PP:          return 2 + abytes;
            OP_SSE, OP_SE:  return 1 + abytes;
            OP_WRSR:        return 2;
            default:        return 1;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Synchronizes the three serial pins into the system clock domain and
// reports serial clock edges and the chip-select release.
// Assumes each serial clock phase lasts several system clocks.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    input  logic mosi_in,
    output logic cs_n_s,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    localparam int W = 3;
    localparam logic [W-1:0] IDLE_V = 3'b100;

    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev;

    // Synchronizer chain; stage 0 samples the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= IDLE_V;
        else        pipe[0] <= {cs_n_in, sck_in, mosi_in};
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Later synchronizer stages.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= IDLE_V;
            else        pipe[g] <= pipe[g-1];
        end
    end

    // Previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_V;
        else        prev <= pipe[STAGES-1];
    end

    assign cs_n_s   = pipe[STAGES-1][2];
    assign mosi_s   = pipe[STAGES-1][0];
    assign sck_rise = pipe[STAGES-1][1] & ~prev[1];
    assign sck_fall = ~pipe[STAGES-1][1] & prev[1];
    assign cs_rise  = pipe[STAGES-1][2] & ~prev[2];
endmodule

// File: rtl/spi_tx_shift.sv
// Output shifter: loads a byte on the first falling edge of each output
// byte and shifts it out MSB first. Clears whenever deselected.
module spi_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic [7:0] load_byte,
    output logic       load_now,
    output logic       miso,
    output logic       oe
);
    logic [2:0] obit;
    logic [7:0] sr;

    assign load_now = shift_en && (obit == 3'd0);

    // Shift register, bit index and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            obit <= 3'd0;
            sr   <= 8'h00;
            miso <= 1'b0;
            oe   <= 1'b0;
        end else if (shift_en) begin
            obit <= obit + 3'd1;
            oe   <= 1'b1;
            if (obit == 3'd0) begin
                miso <= load_byte[7];
                sr   <= {load_byte[6:0], 1'b0};
            end else begin
                miso <= sr[7];
                sr   <= {sr[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/busy_timer.sv
// Simulated internal program/erase cycle: busy for CYCLES clocks after start.
module busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD_V;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R8
    busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flash_cmd_frontend.sv
// Serial flash command front end (SPI mode 0, single data line).
// Decodes opcodes, drives read-type output phases, commits byte-aligned
// write-type commands, gates array access while busy and models
// deep power-down. Assumes serial clock phases span >= 4 system clocks.
module flash_cmd_frontend
    import flash_fe_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          BUSY_CLKS   = 100000,
    parameter int          SYNC_STAGES = 2,
    parameter logic [23:0] DEV_ID      = 24'h5EA117
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_rd_en,
    input  logic [7:0]        arr_rd_data,
    output logic              prog_byte_valid,
    output logic [7:0]        prog_byte,
    output logic              wr_cmd_valid,
    output logic [7:0]        wr_cmd_op,
    output logic [ADDR_W-1:0] wr_cmd_addr
);
    localparam int AB = ADDR_W / 8;
    localparam int BCW = 4;
    localparam logic [BCW-1:0] BC_MAX = '1;

    logic cs_n_s, mosi_s, sck_rise, sck_fall, cs_rise;
    logic busy, busy_go, load_now;

    // Per-command state
    logic [6:0]        sr;
    logic [2:0]        bit_in;
    logic [BCW-1:0]    byte_cnt;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ign_q, dout;
    logic [1:0]        id_idx;
    logic [7:0]        wrsr_q;

    // Persistent state
    logic       wel, pdown;
    logic [5:0] st_hi;

    logic [7:0] nb, status_b, out_b;
    logic       byte_done, aligned, wr_ok;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_in(spi_cs_n), .sck_in(spi_sck), .mosi_in(spi_mosi),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    spi_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n),
        .clear(cs_n_s), .shift_en(sck_fall && dout),
        .load_byte(out_b), .load_now(load_now),
        .miso(spi_miso), .oe(spi_miso_oe)
    );

    busy_timer #(.CYCLES(BUSY_CLKS)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_go), .busy(busy)
    );

    // Opcode is dropped in power-down or when it hits the array while busy.
    function automatic logic blocked(input logic [7:0] op, input logic pd,
                                     input logic bz);
        return (pd && op != OP_RES) ||
               (bz && (op_is_array(op) || op == OP_WRSR));
    endfunction

    assign nb        = {sr, mosi_s};
    assign byte_done = sck_rise && !cs_n_s && (bit_in == 3'd7);
    assign status_b  = {st_hi, wel, busy};

    // Next output byte for the active read-type command.
    always_comb begin
        case (op_q)
            OP_RDSR: out_b = status_b;
            OP_RDID: out_b = DEV_ID[8*(2 - int'(id_idx)) +: 8];
            OP_RES:  out_b = DEV_ID[7:0];
            default: out_b = arr_rd_data;
        endcase
    end

    assign arr_addr  = addr_q;
    assign arr_rd_en = dout && (op_q == OP_READ || op_q == OP_FAST);

    // Commit test at chip-select release.
    assign aligned = cs_rise && (bit_in == 3'd0) && (byte_cnt != '0) && !ign_q;
    assign wr_ok   = aligned && (op_class(op_q) == CL_WRITE) &&
                     (int'(byte_cnt) >= min_len(op_q, AB));
    assign busy_go = wr_ok && op_needs_wel(op_q) && wel;

    // Command shift-in, byte sorting and output-phase control.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            sr <= '0; bit_in <= '0; byte_cnt <= '0; op_q <= '0;
            addr_q <= '0; ign_q <= 1'b0; dout <= 1'b0; id_idx <= '0;
            wrsr_q <= '0; prog_byte_valid <= 1'b0; prog_byte <= '0;
        end else begin
            prog_byte_valid <= 1'b0;
            if (sck_rise) begin
                sr     <= nb[6:0];
                bit_in <= bit_in + 3'd1;
            end
            if (byte_done) begin
                if (byte_cnt != BC_MAX) byte_cnt <= byte_cnt + 1'b1;
                if (byte_cnt == '0) begin
                    op_q  <= nb;
                    ign_q <= blocked(nb, pdown, busy);
                    if (op_class(nb) == CL_READ && !blocked(nb, pdown, busy) &&
                        hdr_len(nb, AB) == 1)
                        dout <= 1'b1;
                end else begin
                    if (int'(byte_cnt) <= AB)
                        addr_q <= {addr_q[ADDR_W-9:0], nb};
                    if (byte_cnt == BCW'(1)) wrsr_q <= nb;
                    if (op_class(op_q) == CL_READ && !ign_q &&
                        int'(byte_cnt) + 1 == hdr_len(op_q, AB))
                        dout <= 1'b1;
                    if (op_q == OP_PP && !ign_q && int'(byte_cnt) > AB) begin
                        prog_byte_valid <= 1'b1;
                        prog_byte       <= nb;
                    end
                end
            end
            if (load_now) begin
                if (arr_rd_en) addr_q <= addr_q + 1'b1;
                id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
            end
        end
    end

    // Latch, status field, power-down flag and accepted-command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0; pdown <= 1'b0; st_hi <= '0;
            wr_cmd_valid <= 1'b0; wr_cmd_op <= '0; wr_cmd_addr <= '0;
        end else begin
            wr_cmd_valid <= 1'b0;
            if (cs_rise && byte_cnt != '0 && !ign_q && op_q == OP_RES)
                pdown <= 1'b0;
            if (wr_ok) begin
                case (op_q)
                    OP_WREN: wel   <= 1'b1;
                    OP_WRDI: wel   <= 1'b0;
                    OP_DP:   pdown <= 1'b1;
                    default: ;
                endcase
            end
            if (busy_go) begin
                wel          <= 1'b0;
                wr_cmd_valid <= 1'b1;
                wr_cmd_op    <= op_q;
                wr_cmd_addr  <= (op_q == OP_BE || op_q == OP_WRSR) ? '0 : addr_q;
                if (op_q == OP_WRSR) st_hi <= wrsr_q[7:2];
            end
        end
    end

    // R1
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_s) |=> !spi_miso_oe);
    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_valid |-> !wel);
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wr_cmd_valid);
    // R5
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_valid |-> $past(cs_rise));
endmodule

// File: tb/sim_flash_cmd_frontend.sv
module sim_flash_cmd_frontend;
    localparam int HP = 6;
    localparam int BUSY = 3000;
    localparam logic [23:0] ID = 24'h5EA117;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe, arr_rd_en, prog_byte_valid, wr_cmd_valid;
    logic [23:0] arr_addr, wr_cmd_addr;
    logic [7:0] arr_rd_data, prog_byte, wr_cmd_op;

    int errors = 0, checks = 0, pulses = 0, pcount = 0;
    bit done = 0;
    logic [7:0] last_op, prog_buf [8];
    logic [23:0] last_addr;
    logic [7:0] tx [16], rx [16];
    logic oe_all, oe_any;
    logic [5:0] hi = 6'd0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign arr_rd_data = mem(arr_addr);

    flash_cmd_frontend #(.BUSY_CLKS(BUSY), .DEV_ID(ID)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .arr_rd_data(arr_rd_data),
        .prog_byte_valid(prog_byte_valid), .prog_byte(prog_byte),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_op(wr_cmd_op),
        .wr_cmd_addr(wr_cmd_addr)
    );

    always @(negedge clk) begin
        if (wr_cmd_valid) begin
            pulses++; last_op = wr_cmd_op; last_addr = wr_cmd_addr;
        end
        if (prog_byte_valid && pcount < 8) begin
            prog_buf[pcount] = prog_byte; pcount++;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_tx(input logic [7:0] a, b, c, d, e, f);
        tx[0] = a; tx[1] = b; tx[2] = c; tx[3] = d; tx[4] = e; tx[5] = f;
    endtask

    task automatic xfer(input int ntx, input int nrx);
        spi_cs_n = 1'b0; oe_all = 1'b1; oe_any = 1'b0;
        for (int k = 0; k < 16; k++) rx[k] = 8'h00;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < ntx + nrx; i++) begin
            spi_mosi = (i < ntx) ? tx[i/8][7 - (i%8)] : 1'b0;
            repeat (HP) @(negedge clk);
            if (i >= ntx) begin
                rx[(i-ntx)/8][7 - ((i-ntx)%8)] = spi_miso;
                oe_all &= spi_miso_oe; oe_any |= spi_miso_oe;
            end
            spi_sck = 1'b1;
            repeat (HP) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        set_tx(op, 0, 0, 0, 0, 0); xfer(8, 0);
    endtask

    task automatic rdsr(output logic [7:0] v);
        set_tx(8'h05, 0, 0, 0, 0, 0); xfer(8, 8); v = rx[0];
    endtask

    logic [7:0] s;
    int p0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        // R13 reset state
        check(!spi_miso_oe && !wr_cmd_valid, "R13", {30'd0, spi_miso_oe, wr_cmd_valid}, 0);
        rdsr(s);
        check(s == 8'h00, "R13 status", s, 8'h00);
        check(oe_all, "R1 oe in data phase", oe_all, 1);
        check(!spi_miso_oe, "R1 oe after release", spi_miso_oe, 0);

        // R5/R6 sweep of cut points for write enable
        for (int n = 1; n <= 24; n++) begin
            cmd1(8'h04);
            set_tx(8'h06, 0, 0, 0, 0, 0); xfer(n, 0);
            rdsr(s);
            check(s == ((n % 8 == 0) ? 8'h02 : 8'h00), $sformatf("R5 R6 cut=%0d", n),
                  s, (n % 8 == 0) ? 8'h02 : 8'h00);
        end
        cmd1(8'h04); rdsr(s);
        check(s == 8'h00, "R6 write disable", s, 8'h00);

        // R7 program without latch dropped
        p0 = pulses;
        set_tx(8'h02, 8'h01, 8'h23, 8'h45, 8'h11, 0); xfer(40, 0);
        check(pulses == p0, "R7 no latch", pulses - p0, 0);

        // R7 R12 accepted program
        cmd1(8'h06); pcount = 0;
        set_tx(8'h02, 8'h01, 8'h23, 8'h45, 8'hC3, 8'h3C); xfer(48, 0);
        check(pulses == p0 + 1 && last_op == 8'h02 && last_addr == 24'h012345,
              "R7 program accepted", {last_op, last_addr}, {8'h02, 24'h012345});
        check(pcount == 2 && prog_buf[0] == 8'hC3 && prog_buf[1] == 8'h3C,
              "R12 program bytes", {prog_buf[0], prog_buf[1]}, 16'hC33C);
        rdsr(s);
        check(s == 8'h01, "R8 R7 busy and latch cleared", s, 8'h01);

        // R9 array access while busy
        set_tx(8'h03, 8'h00, 8'h00, 8'h10, 0, 0); xfer(32, 8);
        check(!oe_any, "R9 read ignored", oe_any, 0);
        cmd1(8'h06);
        p0 = pulses;
        set_tx(8'h02, 8'h00, 8'h00, 8'h00, 8'h77, 0); xfer(40, 0);
        check(pulses == p0, "R9 program ignored", pulses - p0, 0);
        set_tx(8'h05, 0, 0, 0, 0, 0); xfer(8, 24);
        check(rx[0] == 8'h03 && rx[1] == 8'h03 && rx[2] == 8'h03,
              "R9 R1 status repeats while busy", {rx[0], rx[1], rx[2]}, 24'h030303);
        repeat (BUSY) @(negedge clk);
        rdsr(s);
        check(s == 8'h02, "R8 busy ended", s, 8'h02);
        cmd1(8'h04);

        // R3 read and fast read
        set_tx(8'h03, 8'h00, 8'hAB, 8'hFE, 0, 0); xfer(32, 24);
        for (int k = 0; k < 3; k++)
            check(rx[k] == mem(24'h00ABFE + k), "R3 read", rx[k], mem(24'h00ABFE + k));
        set_tx(8'h0B, 8'h12, 8'h34, 8'h56, 8'hFF, 0); xfer(40, 16);
        for (int k = 0; k < 2; k++)
            check(rx[k] == mem(24'h123456 + k), "R3 fast read", rx[k], mem(24'h123456 + k));

        // R2 ID with wrap
        set_tx(8'h9F, 0, 0, 0, 0, 0); xfer(8, 32);
        check({rx[0], rx[1], rx[2], rx[3]} == {ID, ID[23:16]}, "R2 id",
              {rx[0], rx[1], rx[2], rx[3]}, {ID, ID[23:16]});

        // R4 release mid-byte
        set_tx(8'h05, 0, 0, 0, 0, 0); xfer(8, 3);
        check(!spi_miso_oe, "R4 oe off", spi_miso_oe, 0);
        rdsr(s);
        check(s == 8'h00, "R4 next command", s, 8'h00);

        // R10 write status, then misaligned write status
        cmd1(8'h06);
        set_tx(8'h01, 8'hFD, 0, 0, 0, 0); xfer(16, 0);
        repeat (BUSY) @(negedge clk);
        hi = 6'h3F; rdsr(s);
        check(s == {hi, 2'b00}, "R10 status write", s, {hi, 2'b00});
        cmd1(8'h06);
        set_tx(8'h01, 8'h00, 0, 0, 0, 0); xfer(17, 0);
        rdsr(s);
        check(s == {hi, 2'b10}, "R5 misaligned status write", s, {hi, 2'b10});
        set_tx(8'h01, 8'h50, 0, 0, 0, 0); xfer(16, 0);
        repeat (BUSY) @(negedge clk);
        hi = 6'h14; rdsr(s);
        check(s == {hi, 2'b00}, "R10 second value", s, {hi, 2'b00});

        // R7 erases
        cmd1(8'h06); p0 = pulses;
        set_tx(8'hD8, 8'h0A, 8'h00, 8'h00, 0, 0); xfer(36, 0);
        check(pulses == p0, "R5 misaligned erase", pulses - p0, 0);
        xfer(32, 0);
        check(pulses == p0 + 1 && last_op == 8'hD8 && last_addr == 24'h0A0000,
              "R7 sector erase", {last_op, last_addr}, {8'hD8, 24'h0A0000});
        repeat (BUSY) @(negedge clk);
        cmd1(8'hC7);
        check(pulses == p0 + 1, "R7 bulk without latch", pulses - p0, 1);
        cmd1(8'h06); cmd1(8'hC7);
        check(pulses == p0 + 2 && last_op == 8'hC7, "R7 bulk erase", last_op, 8'hC7);
        repeat (BUSY) @(negedge clk);
        cmd1(8'h06);
        set_tx(8'h20, 8'h00, 8'h10, 8'h00, 0, 0); xfer(32, 0);
        check(pulses == p0 + 3 && last_op == 8'h20 && last_addr == 24'h001000,
              "R7 subsector erase", {last_op, last_addr}, {8'h20, 24'h001000});
        repeat (BUSY) @(negedge clk);

        // R11 power-down
        cmd1(8'hB9);
        set_tx(8'h05, 0, 0, 0, 0, 0); xfer(8, 8);
        check(!oe_any, "R11 status ignored", oe_any, 0);
        cmd1(8'h06);
        set_tx(8'hAB, 0, 0, 0, 0, 0); xfer(8, 8);
        check(rx[0] == ID[7:0] && oe_all, "R11 release id", rx[0], ID[7:0]);
        rdsr(s);
        check(s == {hi, 2'b00}, "R11 awake, latch untouched", s, {hi, 2'b00});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule